// File: doc/BRIEF.md
# I2C Slave with Pin-Selected Address

This block is a slave on a two-wire serial bus that gives a host microcontroller access to a small bank of byte registers. The host writes a pointer byte and optional data bytes, or reads bytes back starting at the pointer. Each access advances the pointer, and the pointer wraps at the end of the bank. The device never drives the clock line. The data line is open-drain and is modelled as a drive-low enable together with a sampled input.

One input pin chooses which of two address pairs the slave answers to. In this document an address is the full 8-bit first byte, including the read/write bit in bit 0.

The block also has an acquisition update port that can load new bytes into the bank. A busy flag goes high once a matching address has been acknowledged and stays high until STOP. While the flag is high, update-port writes are discarded, so the host never reads a bank that is changing under it.

Top module: `i2c_sel_slave`

## Requirements
- R1: With `addr_sel` low, the address bytes 0x20 (write) and 0x21 (read) are acknowledged.
- R2: With `addr_sel` high, the address bytes 0x22 (write) and 0x23 (read) are acknowledged. Any other address byte gets no acknowledge, and the slave keeps SDA released until the next START.
- R3: On the synchronised lines, an SDA fall while SCL is high is a START and an SDA rise while SCL is high is a STOP. A STOP releases SDA and returns the slave to idle.
- R4: The slave acknowledges the address byte and every written byte by holding SDA low during the ninth clock. The slave only asserts its drive-low while SCL is low.
- R5: In a write transfer, the first data byte sets the pointer, modulo the bank size (16 by default). Each later byte is stored at the pointer, and the pointer then advances, wrapping from 15 to 0.
- R6: A read returns bytes MSB first, starting at the pointer. Each master acknowledge causes the next byte to be sent, with the pointer advancing and wrapping from 15 to 0. After reset the pointer is 0.
- R7: After a master no-acknowledge, the slave releases SDA and sends nothing more. A master clocking another byte reads 0xFF.
- R8: `bus_busy` rises together with the acknowledge of a matching address. It stays high through a repeated START and falls on STOP. A non-matching address leaves it low.
- R9: An update-port write stores its byte when `bus_busy` is low. It is ignored when `bus_busy` is high.
- R10: After reset, SDA is released, `bus_busy` is low and every bank byte reads as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 10 times the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_sel | input | 1 | Selects the address pair (low: 0x20/0x21, high: 0x22/0x23) |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_drive_low | output | 1 | When high, the pad pulls SDA low |
| bus_busy | output | 1 | High while the host holds an addressed transfer |
| upd_we | input | 1 | Update-port write strobe |
| upd_idx | input | 4 | Update-port byte index |
| upd_data | input | 8 | Update-port byte value |

## Verification
The checker watches five things on every cycle:
- a STOP releases SDA and clears busy on the next cycle;
- busy never drops except on a STOP;
- busy only rises together with an acknowledge drive;
- the slave never starts pulling SDA low while the synchronised SCL is high.

Other behaviours can only be shown by the bench's directed transfers. These are:
- which address bytes are accepted under each select level;
- pointer loading and wrap-around;
- the MSB-first read data;
- the silence after a no-acknowledge;
- discarding update writes while busy.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_WR,
      ST_WR_ACK,
      ST_RD,
      ST_RD_ACK
   } i2cs_state_e;

   // Even base address; the select pin supplies the lowest address bit.
   function automatic logic addr_hit(input logic [6:0] rx,
                                     input logic [6:0] base,
                                     input logic       sel);
      return rx == {base[6:1], sel};
   endfunction

endpackage

// File: rtl/i2cs_line_watch.sv
module i2cs_line_watch #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_evt,
   output logic stop_evt
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] scl_q;
   logic [SYNC_STAGES-1:0] sda_q;
   logic                   scl_p;
   logic                   sda_p;

   for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_q[g] <= 1'b1;
               sda_q[g] <= 1'b1;
            end else begin
               scl_q[g] <= scl_i;
               sda_q[g] <= sda_i;
            end
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_q[g] <= 1'b1;
               sda_q[g] <= 1'b1;
            end else begin
               scl_q[g] <= scl_q[g-1];
               sda_q[g] <= sda_q[g-1];
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_p <= scl_s;
         sda_p <= sda_s;
      end
   end

   assign scl_s     = scl_q[SYNC_STAGES-1];
   assign sda_s     = sda_q[SYNC_STAGES-1];
   assign scl_rise  = scl_s & ~scl_p;
   assign scl_fall  = ~scl_s & scl_p;
   assign start_evt = scl_s & scl_p & sda_p & ~sda_s;
   assign stop_evt  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/i2cs_store.sv
module i2cs_store #(
   parameter int NUM_BYTES = 16,
   parameter int IDX_W     = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_we,
   input  logic [IDX_W-1:0] bus_idx,
   input  logic [7:0]       bus_data,
   input  logic             upd_we,
   input  logic [IDX_W-1:0] upd_idx,
   input  logic [7:0]       upd_data,
   input  logic             hold,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [7:0]       rd_data
);

   logic [7:0] bank [NUM_BYTES];

   for (genvar g = 0; g < NUM_BYTES; g++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            bank[g] <= 8'h00;
         end else if (bus_we && bus_idx == IDX_W'(g)) begin
            bank[g] <= bus_data;
         end else if (upd_we && !hold && upd_idx == IDX_W'(g)) begin
            bank[g] <= upd_data;
         end
      end
   end

   assign rd_data = bank[rd_idx];

endmodule

// File: rtl/i2c_sel_slave.sv
module i2c_sel_slave #(
   parameter int         NUM_BYTES   = 16,
   parameter int         SYNC_STAGES = 2,
   parameter logic [6:0] BASE_ADDR7  = 7'h10,
   localparam int        IDX_W       = $clog2(NUM_BYTES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             addr_sel,
   input  logic             scl_i,
   input  logic             sda_i,
   output logic             sda_drive_low,
   output logic             bus_busy,
   input  logic             upd_we,
   input  logic [IDX_W-1:0] upd_idx,
   input  logic [7:0]       upd_data
);
   import i2cs_pkg::*;

   if (NUM_BYTES < 2 || (NUM_BYTES & (NUM_BYTES - 1)) != 0) begin : g_bad_depth
      $error("NUM_BYTES must be a power of two of at least 2");
   end
   if (BASE_ADDR7[0] != 1'b0) begin : g_bad_base
      $error("BASE_ADDR7 must be even");
   end

   logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;

   i2cs_line_watch #(.SYNC_STAGES(SYNC_STAGES)) watch_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_evt (start_evt),
      .stop_evt  (stop_evt)
   );

   i2cs_state_e      state;
   logic [3:0]       bitcnt;
   logic [7:0]       shreg;
   logic             rw;
   logic             first_wr;
   logic             mack;
   logic [IDX_W-1:0] ptr;
   logic [7:0]       rd_data;
   logic             wr_commit;

   assign wr_commit = (state == ST_WR) && scl_fall && (bitcnt == 4'd8)
                      && !first_wr && !start_evt && !stop_evt;

   i2cs_store #(.NUM_BYTES(NUM_BYTES), .IDX_W(IDX_W)) store_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_we   (wr_commit),
      .bus_idx  (ptr),
      .bus_data (shreg),
      .upd_we   (upd_we),
      .upd_idx  (upd_idx),
      .upd_data (upd_data),
      .hold     (bus_busy),
      .rd_idx   (ptr),
      .rd_data  (rd_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state         <= ST_IDLE;
         bitcnt        <= '0;
         shreg         <= '0;
         rw            <= 1'b0;
         first_wr      <= 1'b0;
         mack          <= 1'b0;
         ptr           <= '0;
         sda_drive_low <= 1'b0;
         bus_busy      <= 1'b0;
      end else if (start_evt) begin
         state         <= ST_ADDR;
         bitcnt        <= '0;
         sda_drive_low <= 1'b0;
      end else if (stop_evt) begin
         state         <= ST_IDLE;
         sda_drive_low <= 1'b0;
         bus_busy      <= 1'b0;
      end else begin
         unique case (state)
            ST_ADDR: begin
               if (scl_rise) begin
                  shreg  <= {shreg[6:0], sda_s};
                  bitcnt <= bitcnt + 4'd1;
               end else if (scl_fall && bitcnt == 4'd8) begin
                  if (addr_hit(shreg[7:1], BASE_ADDR7, addr_sel)) begin
                     sda_drive_low <= 1'b1;
                     bus_busy      <= 1'b1;
                     rw            <= shreg[0];
                     state         <= ST_ADDR_ACK;
                  end else begin
                     state <= ST_IDLE;
                  end
               end
            end
            ST_ADDR_ACK: begin
               if (scl_fall) begin
                  bitcnt <= '0;
                  if (rw) begin
                     shreg         <= rd_data;
                     ptr           <= ptr + 1'b1;
                     sda_drive_low <= ~rd_data[7];
                     state         <= ST_RD;
                  end else begin
                     sda_drive_low <= 1'b0;
                     first_wr      <= 1'b1;
                     state         <= ST_WR;
                  end
               end
            end
            ST_WR: begin
               if (scl_rise) begin
                  shreg  <= {shreg[6:0], sda_s};
                  bitcnt <= bitcnt + 4'd1;
               end else if (scl_fall && bitcnt == 4'd8) begin
                  sda_drive_low <= 1'b1;
                  state         <= ST_WR_ACK;
                  if (first_wr) begin
                     ptr      <= shreg[IDX_W-1:0];
                     first_wr <= 1'b0;
                  end else begin
                     ptr <= ptr + 1'b1;
                  end
               end
            end
            ST_WR_ACK: begin
               if (scl_fall) begin
                  sda_drive_low <= 1'b0;
                  bitcnt        <= '0;
                  state         <= ST_WR;
               end
            end
            ST_RD: begin
               if (scl_rise) begin
                  bitcnt <= bitcnt + 4'd1;
               end else if (scl_fall) begin
                  if (bitcnt == 4'd8) begin
                     sda_drive_low <= 1'b0;
                     state         <= ST_RD_ACK;
                  end else begin
                     shreg         <= {shreg[6:0], 1'b0};
                     sda_drive_low <= ~shreg[6];
                  end
               end
            end
            ST_RD_ACK: begin
               if (scl_rise) begin
                  mack <= ~sda_s;
               end else if (scl_fall) begin
                  if (mack) begin
                     shreg         <= rd_data;
                     ptr           <= ptr + 1'b1;
                     sda_drive_low <= ~rd_data[7];
                     bitcnt        <= '0;
                     state         <= ST_RD;
                  end else begin
                     state <= ST_IDLE;
                  end
               end
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/i2c_sel_slave_chk.sv
module i2c_sel_slave_chk (
   input logic clk,
   input logic rst_n,
   input logic scl_sync,
   input logic stop_seen,
   input logic drive_low,
   input logic busy
);

   // R3: a STOP releases the data line on the following cycle
   assert_stop_releases_R3: assert property (@(posedge clk) disable iff (!rst_n)
      stop_seen |=> !drive_low);

   // R4: the pull-down only begins while the synchronised clock is low
   assert_ack_while_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drive_low) |-> !scl_sync);

   // R8: busy rises only together with an acknowledge drive
   assert_busy_with_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> drive_low);

   // R8: busy stays up until a STOP
   assert_busy_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !stop_seen) |=> busy);

   // R8: STOP clears busy
   assert_busy_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      stop_seen |=> !busy);

endmodule

bind i2c_sel_slave i2c_sel_slave_chk chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .scl_sync  (scl_s),
   .stop_seen (stop_evt),
   .drive_low (sda_drive_low),
   .busy      (bus_busy)
);

// File: tb/i2c_sel_slave_tb_top.sv
module i2c_sel_slave_tb_top;

   localparam int Q = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       addr_sel = 1'b0;
   logic       scl = 1'b1;
   logic       m_low = 1'b0;
   logic       sda_drive_low;
   logic       bus_busy;
   logic       upd_we = 1'b0;
   logic [3:0] upd_idx = '0;
   logic [7:0] upd_data = '0;
   logic       sda_line;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   assign sda_line = ~(m_low | sda_drive_low);

   i2c_sel_slave dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .addr_sel      (addr_sel),
      .scl_i         (scl),
      .sda_i         (sda_line),
      .sda_drive_low (sda_drive_low),
      .bus_busy      (bus_busy),
      .upd_we        (upd_we),
      .upd_idx       (upd_idx),
      .upd_data      (upd_data)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
      end
   endtask

   task automatic bus_start();
      m_low = 1'b0; tick(Q);
      scl = 1'b1;   tick(Q);
      m_low = 1'b1; tick(Q);
      scl = 1'b0;   tick(Q);
   endtask

   task automatic bus_stop();
      m_low = 1'b1; tick(Q);
      scl = 1'b1;   tick(Q);
      m_low = 1'b0; tick(Q);
   endtask

   // acked = 1 when the slave pulled SDA low in the ninth clock
   task automatic wr_byte(input logic [7:0] b, output logic acked);
      for (int i = 7; i >= 0; i--) begin
         m_low = ~b[i]; tick(Q);
         scl = 1'b1;    tick(2 * Q);
         scl = 1'b0;    tick(Q);
      end
      m_low = 1'b0; tick(Q);
      scl = 1'b1;   tick(Q);
      acked = ~sda_line;
      tick(Q);
      scl = 1'b0;   tick(Q);
   endtask

   task automatic rd_byte(input logic give_ack, output logic [7:0] v);
      m_low = 1'b0;
      for (int i = 7; i >= 0; i--) begin
         tick(Q);
         scl = 1'b1; tick(Q);
         v[i] = sda_line;
         tick(Q);
         scl = 1'b0; tick(Q);
      end
      m_low = give_ack; tick(Q);
      scl = 1'b1;       tick(2 * Q);
      scl = 1'b0;       tick(Q);
      m_low = 1'b0;
   endtask

   task automatic t_reset();
      logic [7:0] v;
      logic       a;
      check("R10 drive after reset", {7'b0, sda_drive_low}, 8'h00);
      check("R10 busy after reset", {7'b0, bus_busy}, 8'h00);
      bus_start();
      wr_byte(8'h21, a);
      check("R1 read address 0x21 acked", {7'b0, a}, 8'h01);
      rd_byte(1'b0, v);
      check("R10 R6 bank byte 0 after reset", v, 8'h00);
      bus_stop();
   endtask

   task automatic t_write_seq();
      logic a;
      bus_start();
      wr_byte(8'h20, a);
      check("R1 write address 0x20 acked", {7'b0, a}, 8'h01);
      check("R8 busy after matched address", {7'b0, bus_busy}, 8'h01);
      wr_byte(8'h03, a);
      check("R4 pointer byte acked", {7'b0, a}, 8'h01);
      wr_byte(8'h11, a);
      wr_byte(8'h22, a);
      wr_byte(8'h93, a);
      check("R4 data byte acked", {7'b0, a}, 8'h01);
      bus_stop();
      tick(4);
      check("R3 R8 busy cleared by stop", {7'b0, bus_busy}, 8'h00);
      check("R3 drive released by stop", {7'b0, sda_drive_low}, 8'h00);
   endtask

   task automatic set_ptr_then_read(input logic [7:0] p);
      logic a;
      bus_start();
      wr_byte({6'b001000, addr_sel, 1'b0}, a);
      wr_byte(p, a);
      bus_start();
      check("R8 busy held over repeated start", {7'b0, bus_busy}, 8'h01);
      wr_byte({6'b001000, addr_sel, 1'b1}, a);
      check("R1 R2 read address acked", {7'b0, a}, 8'h01);
   endtask

   task automatic t_read_seq();
      logic [7:0] v;
      set_ptr_then_read(8'h03);
      rd_byte(1'b1, v); check("R5 R6 byte at 3", v, 8'h11);
      rd_byte(1'b1, v); check("R5 R6 byte at 4", v, 8'h22);
      rd_byte(1'b0, v); check("R5 R6 byte at 5", v, 8'h93);
      rd_byte(1'b0, v); check("R7 silent after nack", v, 8'hFF);
      bus_stop();
   endtask

   task automatic t_wrap();
      logic       a;
      logic [7:0] v;
      bus_start();
      wr_byte(8'h20, a);
      wr_byte(8'h1F, a);   // R5: pointer 31 mod 16 = 15
      wr_byte(8'hA5, a);
      wr_byte(8'h5A, a);
      bus_stop();
      set_ptr_then_read(8'h0F);
      rd_byte(1'b1, v); check("R5 byte at 15", v, 8'hA5);
      rd_byte(1'b1, v); check("R6 wrap to byte 0", v, 8'h5A);
      rd_byte(1'b0, v); check("R6 byte 1 untouched", v, 8'h00);
      bus_stop();
   endtask

   task automatic t_nomatch();
      logic       a;
      logic [7:0] v;
      bus_start();
      wr_byte(8'h40, a);
      check("R2 foreign address not acked", {7'b0, a}, 8'h00);
      check("R8 busy low on foreign address", {7'b0, bus_busy}, 8'h00);
      rd_byte(1'b0, v);
      check("R2 line stays released", v, 8'hFF);
      bus_stop();
   endtask

   task automatic t_sel_high();
      logic       a;
      logic [7:0] v;
      addr_sel = 1'b1;
      tick(2);
      bus_start();
      wr_byte(8'h20, a);
      check("R2 0x20 ignored when select high", {7'b0, a}, 8'h00);
      bus_stop();
      bus_start();
      wr_byte(8'h22, a);
      check("R2 0x22 acked", {7'b0, a}, 8'h01);
      wr_byte(8'h08, a);
      wr_byte(8'h6C, a);
      bus_stop();
      set_ptr_then_read(8'h08);
      rd_byte(1'b0, v);
      check("R2 read via 0x23", v, 8'h6C);
      bus_stop();
      addr_sel = 1'b0;
      tick(2);
   endtask

   task automatic upd_write(input logic [3:0] idx, input logic [7:0] d);
      upd_idx = idx; upd_data = d; upd_we = 1'b1;
      tick(1);
      upd_we = 1'b0;
   endtask

   task automatic t_update();
      logic       a;
      logic [7:0] v;
      upd_write(4'd7, 8'hC3);
      tick(2);
      bus_start();
      wr_byte(8'h20, a);
      wr_byte(8'h07, a);
      upd_write(4'd7, 8'h3C);   // R9: busy is high here, must be dropped
      bus_start();
      wr_byte(8'h21, a);
      rd_byte(1'b0, v);
      check("R9 update ignored while busy", v, 8'hC3);
      bus_stop();
   endtask

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(3);
      t_reset();
      t_write_seq();
      t_read_seq();
      t_wrap();
      t_nomatch();
      t_sel_high();
      t_update();
      tick(10);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule